// File: doc/BRIEF.md
# Glitchless gated clock divider sequencer

This block divides a free-running master clock by a programmable integer and drives the result onto a main output. A synchronous enable gates the main output. Turning the main output off never shortens a high pulse, and the divider counter is held cleared while the output is off. Each restart therefore begins at a fixed number of master edges after the enable rises, with the same phase every time.

A second output carries a reference square wave at half the master rate. The enable does not affect it, and a static disable bit removes it without a runt pulse. An active-low power-down request runs an ordered shutdown. The main output stops first, then the reference output stops, and last the oscillator-run request drops. In this state both outputs are released to high impedance. Releasing the request runs the same steps in reverse, and each output begins from a driven low phase.

Both asynchronous inputs pass through two-stage synchronizers on the master clock. All outputs are flip-flop outputs. The divide value and the reference disable bit are treated as synchronous configuration.

Top module: `gated_divider_seq`

## Requirements
- R1: During synchronous reset, div_out=0, ref_out=0, ref_drive=0, div_drive=1 and osc_run=1.
- R2: With the enable pin set up before a rising edge, div_out first goes high on the third master rising edge after that change. The two synchronizer stages plus one output register give this fixed latency.
- R3: While enabled, div_out has a period of N master cycles. It is high for ceil(N/2) cycles, then low for floor(N/2) cycles, starting with the high phase. N values 0 and 1 behave as N=2.
- R4: Once the disable is sampled, a high pulse that is under way runs to its full length. div_out is then held low, and it stays low for as long as the enable remains low. A low div_out is held low at once.
- R5: N is captured only when a run starts. A change to div_n during a run leaves that run's waveform unchanged.
- R6: While driven, ref_out alternates every master cycle and ignores the enable. When ref_off=1 is sampled, the output finishes any high cycle, goes low, and ref_drive drops one cycle later. When ref_off returns to 0, ref_drive rises with ref_out low, and ref_out goes high one cycle after that.
- R7: On a power-down request, the main output first stops exactly as it does for a disable, with its last high pulse at full length. div_drive then falls. After that ref_drive falls, and osc_run falls exactly one cycle after ref_drive.
- R8: While powered down, div_out, ref_out, div_drive, ref_drive and osc_run are all 0, and toggling the enable has no effect.
- R9: On release of power-down, osc_run rises on the third master edge after the pin change. Two edges later, div_drive and ref_drive rise together while both outputs are low. One edge after that, both outputs go high (the enable being high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, free running |
| rst | input | 1 | Synchronous reset, active high |
| oe_async | input | 1 | Output enable for the main output, asynchronous, active high |
| pdn_n_async | input | 1 | Power-down request, asynchronous, active low |
| div_n | input | NW | Divide value N |
| ref_off | input | 1 | 1 disables the reference output |
| div_out | output | 1 | Divided main output |
| ref_out | output | 1 | Reference square wave at half the master rate |
| div_drive | output | 1 | 1 when the main output pad should be driven, 0 for high impedance |
| ref_drive | output | 1 | 1 when the reference pad should be driven, 0 for high impedance |
| osc_run | output | 1 | Request for the oscillator to run |

## Verification
The bench builds the block with NW=4 and two synchronizer stages. Two stages fix the enable-to-output and wake latencies at the exact cycle counts stated in R2 and R9, so every scoreboard entry can be tied to one master cycle. A 4-bit divide value covers the degenerate values 0 and 1, both odd and even N, and a change of N during a run with the new value still inside the range. The disable points are chosen so that one lands mid-high-pulse, one on the last high cycle and one just before a new period would begin.

// File: rtl/gds_pkg.sv
package gds_pkg;
  typedef enum logic [2:0] {
    SQ_RUN     = 3'd0,
    SQ_MAIN_DN = 3'd1,
    SQ_REF_DN  = 3'd2,
    SQ_SLEEP   = 3'd3,
    SQ_OSC_UP  = 3'd4,
    SQ_REF_UP  = 3'd5
  } seq_e;
endpackage

// File: rtl/gds_sync.sv
module gds_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= {STAGES{RST_VAL}};
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/gds_div_core.sv
module gds_div_core #(
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          want,
  input  logic [NW-1:0] n,
  output logic          q,
  output logic          idle
);
  localparam logic [NW-1:0] NMIN = NW'(2);
  localparam logic [NW-1:0] ONE  = NW'(1);

  logic [NW-1:0] n_lat, cnt, cnt_nx, half;
  logic          running, q_nx;

  always_comb begin
    half   = {1'b0, n_lat[NW-1:1]} + {{(NW-1){1'b0}}, n_lat[0]};
    cnt_nx = (cnt == n_lat - ONE) ? '0 : cnt + ONE;
    q_nx   = (cnt_nx < half);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
      q       <= 1'b0;
      n_lat   <= NMIN;
    end else if (!running) begin
      cnt <= '0;
      q   <= 1'b0;
      if (want) begin
        running <= 1'b1;
        q       <= 1'b1;
        n_lat   <= (n < NMIN) ? NMIN : n;
      end
    end else if (!want && (!q || !q_nx)) begin
      // stop only on a low level or at the natural falling edge
      running <= 1'b0;
      cnt     <= '0;
      q       <= 1'b0;
    end else begin
      cnt <= cnt_nx;
      q   <= q_nx;
    end
  end

  assign idle = !running;
endmodule

// File: rtl/gds_ref_core.sv
module gds_ref_core (
  input  logic clk,
  input  logic rst,
  input  logic want,
  output logic r,
  output logic drv,
  output logic stopped
);
  always_ff @(posedge clk) begin
    if (rst) begin
      r   <= 1'b0;
      drv <= 1'b0;
    end else if (want) begin
      if (!drv) begin
        drv <= 1'b1;   // drive low for one cycle before toggling
        r   <= 1'b0;
      end else begin
        r <= ~r;
      end
    end else begin
      r   <= 1'b0;
      drv <= r;        // release one cycle after the last low
    end
  end

  assign stopped = !drv;
endmodule

// File: rtl/gated_divider_seq.sv
module gated_divider_seq
  import gds_pkg::*;
#(
  parameter int NW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          oe_async,
  input  logic          pdn_n_async,
  input  logic [NW-1:0] div_n,
  input  logic          ref_off,
  output logic          div_out,
  output logic          ref_out,
  output logic          div_drive,
  output logic          ref_drive,
  output logic          osc_run
);
  logic oe_s, pdn_n_s, pd_req;
  logic main_want, ref_want, main_idle, ref_stopped;
  seq_e state, state_nx;

  gds_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_oe (
    .clk(clk), .rst(rst), .d(oe_async), .q(oe_s)
  );
  gds_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pd (
    .clk(clk), .rst(rst), .d(pdn_n_async), .q(pdn_n_s)
  );

  assign pd_req    = !pdn_n_s;
  assign main_want = (state == SQ_RUN) && oe_s;
  assign ref_want  = ((state == SQ_RUN) || (state == SQ_MAIN_DN) ||
                      (state == SQ_REF_UP)) && !ref_off;

  always_comb begin
    state_nx = state;
    case (state)
      SQ_RUN:     if (pd_req)      state_nx = SQ_MAIN_DN;
      SQ_MAIN_DN: if (main_idle)   state_nx = SQ_REF_DN;
      SQ_REF_DN:  if (ref_stopped) state_nx = SQ_SLEEP;
      SQ_SLEEP:   if (!pd_req)     state_nx = SQ_OSC_UP;
      SQ_OSC_UP:                   state_nx = SQ_REF_UP;
      SQ_REF_UP:                   state_nx = SQ_RUN;
      default:                     state_nx = SQ_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_RUN;
      osc_run   <= 1'b1;
      div_drive <= 1'b1;
    end else begin
      state     <= state_nx;
      osc_run   <= (state_nx != SQ_SLEEP);
      div_drive <= (state_nx == SQ_RUN) || (state_nx == SQ_MAIN_DN);
    end
  end

  gds_div_core #(.NW(NW)) u_div (
    .clk(clk), .rst(rst), .want(main_want), .n(div_n),
    .q(div_out), .idle(main_idle)
  );

  gds_ref_core u_ref (
    .clk(clk), .rst(rst), .want(ref_want),
    .r(ref_out), .drv(ref_drive), .stopped(ref_stopped)
  );
endmodule

// File: rtl/gds_checker.sv
module gds_checker (
  input logic clk,
  input logic rst,
  input logic div_out,
  input logic ref_out,
  input logic div_drive,
  input logic ref_drive,
  input logic osc_run,
  input logic main_want
);
  // R4: a low main output with the enable withdrawn stays low
  a_r4_hold_low: assert property (@(posedge clk) disable iff (rst)
    (!main_want && !div_out) |=> !div_out);

  // R6: reference high phases last exactly one cycle
  a_r6_ref_single: assert property (@(posedge clk) disable iff (rst)
    ref_out |=> !ref_out);

  // R8: a released main pad carries no high level
  a_r8_main_quiet: assert property (@(posedge clk) disable iff (rst)
    !div_drive |-> !div_out);

  // R7: oscillator stops only after both pads are released
  a_r7_osc_last: assert property (@(posedge clk) disable iff (rst)
    !osc_run |-> (!div_drive && !ref_drive));

  // R9: oscillator comes back before the main pad is driven
  a_r9_osc_first: assert property (@(posedge clk) disable iff (rst)
    $rose(osc_run) |=> !div_drive);

  // R9: each pad starts from a driven low
  a_r9_ref_low_start: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_drive) |-> !ref_out);

  a_r9_main_low_start: assert property (@(posedge clk) disable iff (rst)
    $rose(div_drive) |-> !div_out);
endmodule

bind gated_divider_seq gds_checker u_chk (
  .clk(clk), .rst(rst), .div_out(div_out), .ref_out(ref_out),
  .div_drive(div_drive), .ref_drive(ref_drive), .osc_run(osc_run),
  .main_want(main_want)
);

// File: tb/tb_gated_divider_seq.sv
module tb_gated_divider_seq;
  localparam int NW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic oe_async = 1'b0;
  logic pdn_n_async = 1'b1;
  logic [NW-1:0] div_n = 4'd5;
  logic ref_off = 1'b0;
  logic div_out, ref_out, div_drive, ref_drive, osc_run;

  int cyc = 0;
  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  typedef struct {
    int    cyc;
    logic  val;
    string req;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  gated_divider_seq #(.NW(NW), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .oe_async(oe_async), .pdn_n_async(pdn_n_async),
    .div_n(div_n), .ref_off(ref_off), .div_out(div_out), .ref_out(ref_out),
    .div_drive(div_drive), .ref_drive(ref_drive), .osc_run(osc_run)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s cycle %0d actual=%b expected=%b", req, cyc, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor for the main output
  always @(negedge clk) begin
    if (!rst) begin
      while (sb.size() > 0 && sb[0].cyc <= cyc) begin
        exp_t e;
        e = sb.pop_front();
        nchk++;
        if (e.cyc != cyc || div_out !== e.val) begin
          nerr++;
          $display("FAIL %s cycle %0d actual=%b expected=%b", e.req, cyc, div_out, e.val);
        end
      end
    end
  end

  function automatic void push(input int c, input logic v, input string req);
    exp_t e;
    e.cyc = c; e.val = v; e.req = req;
    sb.push_back(e);
  endfunction

  // driver: one enable window, expectations derived from R2..R5
  task automatic run_main(input int n, input int on_len);
    int c, ne, h;
    logic prev, f;
    ne = (n < 2) ? 2 : n;
    h  = (ne + 1) / 2;
    div_n = NW'(n);
    @(negedge clk);
    c = cyc;
    oe_async = 1'b1;
    push(c + 1, 1'b0, "R2");
    push(c + 2, 1'b0, "R2");
    for (int k = 0; k < on_len; k++)
      push(c + 3 + k, ((k % ne) < h), (k == 0) ? "R2" : "R3");
    prev = ((on_len - 1) % ne) < h;
    for (int k = on_len; k < on_len + ne + 3; k++) begin
      f = prev && ((k % ne) < h);
      push(c + 3 + k, f, "R4");
      prev = f;
    end
    repeat (5) @(negedge clk);
    div_n = NW'(n + 3);  // R5: must not disturb this run
    while (cyc < c + on_len) @(negedge clk);
    oe_async = 1'b0;
    repeat (ne + 10) @(negedge clk);
    div_n = NW'(n);
  endtask

  task automatic ref_off_trial(input logic phase);
    logic r0;
    while (ref_out !== phase) @(negedge clk);
    r0 = ref_out;
    ref_off = 1'b1;
    @(negedge clk);
    chk("R6 ref low after off", ref_out, 1'b0);
    chk("R6 drive held for last low", ref_drive, r0);
    @(negedge clk);
    chk("R6 drive released", ref_drive, 1'b0);
    repeat (3) @(negedge clk);
    chk("R6 stays off", ref_out | ref_drive, 1'b0);
    ref_off = 1'b0;
    @(negedge clk);
    chk("R6 drive back low phase", ref_drive, 1'b1);
    chk("R6 starts low", ref_out, 1'b0);
    @(negedge clk);
    chk("R6 first high", ref_out, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int p, td, tr, to, hl, w;
    bit rose;
    logic r0;
    repeat (3) @(negedge clk);
    chk("R1 div_out", div_out, 1'b0);
    chk("R1 ref_out", ref_out, 1'b0);
    chk("R1 ref_drive", ref_drive, 1'b0);
    chk("R1 div_drive", div_drive, 1'b1);
    chk("R1 osc_run", osc_run, 1'b1);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    run_main(5, 11);  // disable mid-high: pulse completes
    run_main(4, 10);  // disable on last high cycle
    run_main(4, 8);   // disable just before new period: held low
    run_main(0, 7);
    run_main(1, 6);
    run_main(3, 9);
    run_main(8, 14);

    // R6: reference toggles regardless of enable activity
    for (int i = 0; i < 8; i++) begin
      r0 = ref_out;
      oe_async = ~oe_async;
      @(negedge clk);
      chk("R6 ref alternates", ref_out, ~r0);
    end
    oe_async = 1'b0;
    repeat (12) @(negedge clk);
    ref_off_trial(1'b1);
    ref_off_trial(1'b0);

    // R7: ordered power-down with N=5 running
    div_n = 4'd5;
    oe_async = 1'b1;
    repeat (12) @(negedge clk);
    p = cyc;
    pdn_n_async = 1'b0;
    td = -1; tr = -1; to = -1; hl = 0; rose = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (div_out) begin
        if (hl == 0) rose = 1;
        hl++;
      end else begin
        if (hl > 0 && rose) chk_int("R7 last pulse full", hl, 3);
        hl = 0;
      end
      if (td < 0 && !div_drive) td = cyc;
      if (tr < 0 && !ref_drive) tr = cyc;
      if (to < 0 && !osc_run) to = cyc;
    end
    chk("R7 main released after request", (td > p + 3) && (td <= p + 10), 1'b1);
    chk("R7 reference after main", tr > td, 1'b1);
    chk_int("R7 oscillator one cycle after reference", to, tr + 1);

    // R8: sleep state ignores the enable
    for (int i = 0; i < 10; i++) begin
      oe_async = ~oe_async;
      @(negedge clk);
      chk("R8 all quiet", div_out | ref_out | div_drive | ref_drive | osc_run, 1'b0);
    end
    oe_async = 1'b1;
    repeat (4) @(negedge clk);

    // R9: wake sequence
    w = cyc;
    pdn_n_async = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 osc still off", osc_run, 1'b0);
    @(negedge clk);
    chk("R9 osc first", osc_run, 1'b1);
    chk("R9 pads not yet driven", div_drive | ref_drive, 1'b0);
    @(negedge clk);
    chk("R9 pads not yet driven", div_drive | ref_drive, 1'b0);
    @(negedge clk);
    chk("R9 ref pad driven", ref_drive, 1'b1);
    chk("R9 main pad driven", div_drive, 1'b1);
    chk("R9 both low", div_out | ref_out, 1'b0);
    @(negedge clk);
    chk_int("R9 wake edge count", cyc, w + 6);
    chk("R9 main first high", div_out, 1'b1);
    chk("R9 ref first high", ref_out, 1'b1);

    oe_async = 1'b0;
    repeat (20) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule